// File: doc/BRIEF.md
# Command Ring Fetch Front End

This block sits at the head of an asynchronous copy engine. Host software places command dwords in a circular ring in memory and moves a write pointer forward. The block follows with its own read pointer. It reads one dword at a time from a simple memory port and passes each dword to a downstream packet decoder over a valid/ready link. When software asks for it, the block copies every new read-pointer value to a write-back address so the host can poll memory instead of the register.

Software sets the block up through a small register window indexed by `reg_addr_i`:

| Index | Register |
|---|---|
| 0 | control |
| 1 | ring base |
| 2 | read pointer |
| 3 | write pointer |
| 4 | write-back address high |
| 5 | write-back address low |
| 6 | status (read only) |

A synchronous soft reset clears the ring position without touching the configuration.

Top module: `ring_fetch_ctrl`

## Requirements
- R1: Control bit 0 enables fetching. `mem_req_o` is never high while this bit reads 0. A read that was already granted still completes.
- R2: Control bits [5:1] give the ring size as log2 of the dword count. Values above MAX_LOG2 are treated as MAX_LOG2. The read pointer wraps modulo the ring size.
- R3: The base register holds the ring byte address shifted right by 8. Each fetch address is base*256 + read pointer.
- R4: Both pointer registers are byte offsets whose bits [1:0] read 0. A fetch is requested only when the ring is enabled, the pointers differ and `pkt_ready_i` is high. The read pointer moves forward by 4 for each dword the decoder accepts.
- R5: Fetched dwords reach `pkt_data_o` in ring order. A dword stays valid and unchanged until `pkt_ready_i` accepts it.
- R6: Control bit 12 enables write-back. After each read-pointer advance, `wb_req_o` rises and carries the current read pointer to the address {high[7:0], low[31:2], 2'b00}. The request is held until `wb_ack_i`, and only one is outstanding at a time. With bit 12 clear, no write-back is issued.
- R7: Status bit 0 reads 1 exactly when the pointers are equal and no fetch is in progress.
- R8: `soft_rst_i` zeroes both pointers and drops any in-flight fetch and write-back. Control, base and write-back address are kept.
- R9: A write to the write pointer while the ring is enabled, idle and `pkt_ready_i` is high raises `mem_req_o` in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of ring position and in-flight state |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on index) |
| mem_req_o | output | 1 | Dword read request |
| mem_addr_o | output | 40 | Byte address of the read |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| pkt_valid_o | output | 1 | Dword available for the decoder |
| pkt_data_o | output | 32 | Dword to the decoder |
| pkt_ready_i | input | 1 | Decoder accepts the dword |
| wb_req_o | output | 1 | Read-pointer write-back request |
| wb_addr_o | output | 40 | Write-back byte address |
| wb_data_o | output | 32 | Read pointer being written back |
| wb_ack_i | input | 1 | Write-back accepted |

## Verification
The fetch path is driven with four patterns:
- A straight run from offset zero, which checks the base-plus-offset address and the order of the dwords.
- A run that starts near the top of a 16-dword ring and wraps past zero, which checks the wrap mask against a plain increment.
- A run in a 4-dword ring, which checks that the size field sets the mask.
- A run held back by a low ready, which checks the ready gating and data hold against free-running fetch.

Write-back is observed with the enable bit set and clear, which separates issuing on advance from issuing always. A soft reset taken while a dword waits downstream shows that the ring position is cleared while the configuration survives.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] RA_BASE   = 3'd1;
  localparam logic [REG_AW-1:0] RA_RPTR   = 3'd2;
  localparam logic [REG_AW-1:0] RA_WPTR   = 3'd3;
  localparam logic [REG_AW-1:0] RA_WBHI   = 3'd4;
  localparam logic [REG_AW-1:0] RA_WBLO   = 3'd5;
  localparam logic [REG_AW-1:0] RA_STATUS = 3'd6;

  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_SZ_LSB = 1;
  localparam int CTRL_SZ_W   = 5;
  localparam int CTRL_WB_BIT = 12;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WAIT = 2'd1,
    FS_HOLD = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/ring_regs.sv
module ring_regs
  import ring_fetch_pkg::*;
#(
  parameter int MAX_LOG2 = 14,
  parameter int BASE_W   = 32,
  parameter int PTR_W    = MAX_LOG2 + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              adv_i,
  input  logic              busy_i,
  output logic              en_o,
  output logic              wb_en_o,
  output logic [BASE_W-1:0] base_o,
  output logic [PTR_W-1:0]  rptr_o,
  output logic [PTR_W-1:0]  wptr_o,
  output logic [7:0]        wb_hi_o,
  output logic [29:0]       wb_lo_o,
  output logic              idle_o
);
  logic                 en_q, wb_en_q;
  logic [CTRL_SZ_W-1:0] sz_q, sz_eff;
  logic [BASE_W-1:0]    base_q;
  logic [PTR_W-1:0]     rptr_q, wptr_q, byte_mask;
  logic [7:0]           wb_hi_q;
  logic [29:0]          wb_lo_q;

  // clamp size, then build a dword-aligned byte mask
  assign sz_eff    = (sz_q > CTRL_SZ_W'(MAX_LOG2)) ? CTRL_SZ_W'(MAX_LOG2) : sz_q;
  assign byte_mask = ({PTR_W{1'b1}} >> (CTRL_SZ_W'(MAX_LOG2) - sz_eff)) & ~PTR_W'(3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      wb_en_q <= 1'b0;
      sz_q    <= '0;
      base_q  <= '0;
      wb_hi_q <= '0;
      wb_lo_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_CTRL: begin
          en_q    <= wdata_i[CTRL_EN_BIT];
          sz_q    <= wdata_i[CTRL_SZ_LSB +: CTRL_SZ_W];
          wb_en_q <= wdata_i[CTRL_WB_BIT];
        end
        RA_BASE: base_q  <= wdata_i[BASE_W-1:0];
        RA_WBHI: wb_hi_q <= wdata_i[7:0];
        RA_WBLO: wb_lo_q <= wdata_i[31:2];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
      wptr_q <= '0;
    end else if (soft_rst_i) begin
      rptr_q <= '0;
      wptr_q <= '0;
    end else begin
      if (we_i && addr_i == RA_RPTR)  rptr_q <= wdata_i[PTR_W-1:0] & ~PTR_W'(3);
      else if (adv_i)                 rptr_q <= (rptr_q + PTR_W'(4)) & byte_mask;
      if (we_i && addr_i == RA_WPTR)  wptr_q <= wdata_i[PTR_W-1:0] & ~PTR_W'(3);
    end
  end

  assign idle_o = (rptr_q == wptr_q) && !busy_i;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL: begin
        rdata_o[CTRL_EN_BIT]               = en_q;
        rdata_o[CTRL_SZ_LSB +: CTRL_SZ_W]  = sz_q;
        rdata_o[CTRL_WB_BIT]               = wb_en_q;
      end
      RA_BASE:   rdata_o[BASE_W-1:0] = base_q;
      RA_RPTR:   rdata_o[PTR_W-1:0]  = rptr_q;
      RA_WPTR:   rdata_o[PTR_W-1:0]  = wptr_q;
      RA_WBHI:   rdata_o[7:0]        = wb_hi_q;
      RA_WBLO:   rdata_o[31:2]       = wb_lo_q;
      RA_STATUS: rdata_o[0]          = idle_o;
      default: ;
    endcase
  end

  assign en_o    = en_q;
  assign wb_en_o = wb_en_q;
  assign base_o  = base_q;
  assign rptr_o  = rptr_q;
  assign wptr_o  = wptr_q;
  assign wb_hi_o = wb_hi_q;
  assign wb_lo_o = wb_lo_q;
endmodule

// File: rtl/ring_fetch_fsm.sv
module ring_fetch_fsm
  import ring_fetch_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int BASE_W = 32,
  parameter int ADDR_W = BASE_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              en_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [PTR_W-1:0]  rptr_i,
  input  logic [PTR_W-1:0]  wptr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              pkt_valid_o,
  output logic [31:0]       pkt_data_o,
  input  logic              pkt_ready_i,
  output logic              adv_o,
  output logic              busy_o
);
  fetch_state_e state_q, state_d;
  logic [31:0]  data_q;
  logic         can_fetch;

  assign can_fetch  = en_i && (rptr_i != wptr_i) && pkt_ready_i && !soft_rst_i;
  assign mem_req_o  = (state_q == FS_IDLE) && can_fetch;
  assign mem_addr_o = {base_i, 8'h00} + ADDR_W'(rptr_i);

  always_comb begin
    state_d = state_q;
    case (state_q)
      FS_IDLE: if (mem_req_o && mem_gnt_i) state_d = FS_WAIT;
      FS_WAIT: if (mem_rvalid_i)           state_d = FS_HOLD;
      FS_HOLD: if (pkt_ready_i)            state_d = FS_IDLE;
      default:                             state_d = FS_IDLE;
    endcase
    if (soft_rst_i) state_d = FS_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == FS_WAIT && mem_rvalid_i) data_q <= mem_rdata_i;
    end
  end

  assign pkt_valid_o = (state_q == FS_HOLD);
  assign pkt_data_o  = data_q;
  assign adv_o       = pkt_valid_o && pkt_ready_i && !soft_rst_i;
  assign busy_o      = (state_q != FS_IDLE);
endmodule

// File: rtl/ring_wb.sv
module ring_wb #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wb_en_i,
  input  logic              adv_i,
  input  logic [PTR_W-1:0]  rptr_i,
  input  logic [7:0]        wb_hi_i,
  input  logic [29:0]       wb_lo_i,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [31:0]       wb_data_o,
  input  logic              wb_ack_i
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= 1'b0;
    else if (soft_rst_i)        pend_q <= 1'b0;
    else if (adv_i && wb_en_i)  pend_q <= 1'b1;
    else if (wb_req_o && wb_ack_i) pend_q <= 1'b0;
    else if (!wb_en_i)          pend_q <= 1'b0;
  end

  // data follows the live pointer, so back-to-back advances coalesce
  assign wb_req_o  = pend_q && wb_en_i;
  assign wb_addr_o = ADDR_W'({wb_hi_i, wb_lo_i, 2'b00});
  assign wb_data_o = 32'(rptr_i);
endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
  import ring_fetch_pkg::*;
#(
  parameter int MAX_LOG2 = 14,
  parameter int BASE_W   = 32,
  localparam int PTR_W   = MAX_LOG2 + 2,
  localparam int ADDR_W  = BASE_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              pkt_valid_o,
  output logic [31:0]       pkt_data_o,
  input  logic              pkt_ready_i,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [31:0]       wb_data_o,
  input  logic              wb_ack_i
);
  logic              en, wb_en, adv, busy, idle;
  logic [BASE_W-1:0] base;
  logic [PTR_W-1:0]  rptr, wptr;
  logic [7:0]        wb_hi;
  logic [29:0]       wb_lo;

  ring_regs #(.MAX_LOG2(MAX_LOG2), .BASE_W(BASE_W), .PTR_W(PTR_W)) i_regs (
    .clk_i, .rst_ni, .soft_rst_i,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .adv_i(adv), .busy_i(busy),
    .en_o(en), .wb_en_o(wb_en), .base_o(base), .rptr_o(rptr), .wptr_o(wptr),
    .wb_hi_o(wb_hi), .wb_lo_o(wb_lo), .idle_o(idle)
  );

  ring_fetch_fsm #(.PTR_W(PTR_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) i_fsm (
    .clk_i, .rst_ni, .soft_rst_i,
    .en_i(en), .base_i(base), .rptr_i(rptr), .wptr_i(wptr),
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .pkt_valid_o, .pkt_data_o, .pkt_ready_i,
    .adv_o(adv), .busy_o(busy)
  );

  ring_wb #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) i_wb (
    .clk_i, .rst_ni, .soft_rst_i,
    .wb_en_i(wb_en), .adv_i(adv), .rptr_i(rptr),
    .wb_hi_i(wb_hi), .wb_lo_i(wb_lo),
    .wb_req_o, .wb_addr_o, .wb_data_o, .wb_ack_i
  );
endmodule

// File: rtl/ring_fetch_checker.sv
module ring_fetch_checker #(
  parameter int PTR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_i,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic             en,
  input logic [PTR_W-1:0] rptr,
  input logic [PTR_W-1:0] wptr,
  input logic             idle,
  input logic             mem_req_o,
  input logic             pkt_valid_o,
  input logic [31:0]      pkt_data_o,
  input logic             pkt_ready_i,
  input logic             wb_req_o,
  input logic             wb_ack_i
);
  AST_NO_REQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> en);                                                     // R1
  AST_NO_REQ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (rptr != wptr) && pkt_ready_i);                          // R4
  AST_RPTR_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_valid_o && pkt_ready_i) && !soft_rst_i && !(reg_we_i && reg_addr_i == 3'd2)
    |=> $stable(rptr));                                                    // R4
  AST_PKT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i && !soft_rst_i |=> pkt_valid_o && $stable(pkt_data_o)); // R5
  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o && !wb_ack_i && !soft_rst_i && !reg_we_i |=> wb_req_o);       // R6
  AST_IDLE_NO_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !pkt_valid_o);                                                // R7
  AST_SOFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> rptr == '0 && wptr == '0 && !pkt_valid_o);              // R8
endmodule

bind ring_fetch_ctrl ring_fetch_checker #(.PTR_W(PTR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .en(en), .rptr(rptr), .wptr(wptr), .idle(idle),
  .mem_req_o(mem_req_o), .pkt_valid_o(pkt_valid_o), .pkt_data_o(pkt_data_o),
  .pkt_ready_i(pkt_ready_i), .wb_req_o(wb_req_o), .wb_ack_i(wb_ack_i)
);

// File: tb/test_ring_fetch_ctrl.sv
module test_ring_fetch_ctrl;
  localparam int AW = 40;
  localparam logic [31:0] BASE = 32'h0001_2345;

  logic          clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic          mem_req, mem_gnt, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_rdata = '0;
  logic          pkt_valid, pkt_ready = 1'b0;
  logic [31:0]   pkt_data;
  logic          wb_req, wb_ack = 1'b0;
  logic [AW-1:0] wb_addr;
  logic [31:0]   wb_data;

  int n_chk = 0, n_fail = 0, cyc = 0, req_cnt = 0, wb_cnt = 0;
  logic [31:0]   wb_last_data = '0;
  logic [AW-1:0] wb_last_addr = '0;

  always #2.5 clk = ~clk;
  assign mem_gnt = 1'b1;

  ring_fetch_ctrl i_ring_fetch_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .pkt_valid_o(pkt_valid), .pkt_data_o(pkt_data), .pkt_ready_i(pkt_ready),
    .wb_req_o(wb_req), .wb_addr_o(wb_addr), .wb_data_o(wb_data), .wb_ack_i(wb_ack)
  );

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    return a[31:0] ^ 32'h5A5A_5A5A;
  endfunction

  // memory and write-back responders
  always @(posedge clk) begin
    mem_rvalid <= mem_req && mem_gnt;
    mem_rdata  <= mem_word(mem_addr);
    wb_ack     <= wb_req && !wb_ack;
    if (mem_req && mem_gnt) req_cnt <= req_cnt + 1;
    if (wb_req && wb_ack) begin
      wb_cnt       <= wb_cnt + 1;
      wb_last_data <= wb_data;
      wb_last_addr <= wb_addr;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // accept n dwords, expecting ring indices first, first+1, ... wrapped by mask
  task automatic consume(input int n, input int first, input int mask, input string req);
    int got = 0, t = 0;
    @(negedge clk); pkt_ready = 1'b1;
    while (got < n && t < 400) begin
      if (pkt_valid) begin
        logic [AW-1:0] ea;
        ea = {BASE, 8'h00} + AW'(((first + got) & mask) * 4);
        check(pkt_data == mem_word(ea), req, pkt_data, mem_word(ea));
        got++;
      end
      if (got < n) @(negedge clk);
      t++;
    end
    check(got == n, req, got, n);
    @(negedge clk); pkt_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(3'd0, d); check(d == 0, "R1 ctrl after reset", d, 0);
    reg_rd(3'd2, d); check(d == 0, "R4 rptr after reset", d, 0);
    reg_rd(3'd6, d); check(d[0] == 1'b1, "R7 idle after reset", d, 1);
    check(!pkt_valid && !mem_req, "R5 no traffic after reset", {pkt_valid, mem_req}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    reg_wr(3'd1, BASE);
    reg_wr(3'd4, 32'h0000_0012);
    reg_wr(3'd5, 32'h0000_1007);
    reg_wr(3'd0, 32'h0000_1009);          // enable, size 16 dwords, write-back on
    @(negedge clk); pkt_ready = 1'b1;
    @(negedge clk); we = 1'b1; addr = 3'd3; wdata = 32'd20;
    @(negedge clk); we = 1'b0;
    check(mem_req == 1'b1, "R9 fetch next cycle after wptr write", mem_req, 1);
    consume(5, 0, 15, "R3 R5 linear run");
    idle_cycles(6);
    reg_rd(3'd2, d); check(d == 20, "R4 rptr after five dwords", d, 20);
    reg_rd(3'd6, d); check(d[0] == 1'b1, "R7 idle when caught up", d, 1);
    check(wb_last_data == 20, "R6 write-back value", wb_last_data, 20);
    check(wb_last_addr == 40'h12_0000_1004, "R6 write-back address", wb_last_addr, 40'h12_0000_1004);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    int r0;
    reg_wr(3'd0, 32'h0000_1008);          // disabled
    reg_wr(3'd2, 32'd58);                 // low bits dropped -> 56
    reg_rd(3'd2, d); check(d == 56, "R4 byte offset low bits clear", d, 56);
    reg_wr(3'd3, 32'd8);
    reg_rd(3'd6, d); check(d[0] == 1'b0, "R7 not idle with pointers apart", d, 0);
    @(negedge clk); pkt_ready = 1'b1; r0 = req_cnt;
    idle_cycles(10);
    check(req_cnt == r0, "R1 no fetch while disabled", req_cnt, r0);
    pkt_ready = 1'b0;
    reg_wr(3'd0, 32'h0000_1009);
    consume(4, 14, 15, "R2 wrap in 16-dword ring");
    idle_cycles(4);
    reg_rd(3'd2, d); check(d == 8, "R2 rptr after wrap", d, 8);
  endtask

  task automatic t_small_ring();
    logic [31:0] d;
    int r0;
    reg_wr(3'd0, 32'h0000_1005);          // size 4 dwords
    reg_wr(3'd3, 32'd4);
    consume(3, 2, 3, "R2 wrap in 4-dword ring");
    idle_cycles(4);
    reg_rd(3'd2, d); check(d == 4, "R2 rptr in small ring", d, 4);
    // back-pressure
    r0 = req_cnt;
    reg_wr(3'd3, 32'd12);
    idle_cycles(10);
    check(req_cnt == r0 && !pkt_valid, "R4 no fetch without ready", req_cnt, r0);
    consume(2, 1, 3, "R4 fetch after ready");
  endtask

  task automatic t_wb_off();
    logic [31:0] d;
    int w0;
    reg_wr(3'd0, 32'h0000_0005);          // write-back off
    idle_cycles(2);
    w0 = wb_cnt;
    reg_wr(3'd3, 32'd0);
    consume(1, 3, 3, "R6 fetch with write-back off");
    idle_cycles(6);
    check(wb_cnt == w0 && !wb_req, "R6 no write-back when disabled", wb_cnt, w0);
    reg_rd(3'd2, d); check(d == 0, "R2 rptr wrapped to zero", d, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    logic [31:0] held;
    reg_wr(3'd3, 32'd8);
    @(negedge clk); pkt_ready = 1'b1;
    @(negedge clk); pkt_ready = 1'b0;
    idle_cycles(4);
    check(pkt_valid == 1'b1, "R5 dword held while not ready", pkt_valid, 1);
    held = pkt_data;
    idle_cycles(2);
    check(pkt_data == held, "R5 held dword stable", pkt_data, held);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check(!pkt_valid, "R8 in-flight dropped", pkt_valid, 0);
    reg_rd(3'd2, d); check(d == 0, "R8 rptr cleared", d, 0);
    reg_rd(3'd3, d); check(d == 0, "R8 wptr cleared", d, 0);
    reg_rd(3'd0, d); check(d == 32'h5, "R8 control kept", d, 32'h5);
    reg_rd(3'd1, d); check(d == BASE, "R8 base kept", d, BASE);
    reg_rd(3'd6, d); check(d[0] == 1'b1, "R7 idle after soft reset", d, 1);
  endtask

  initial begin
    idle_cycles(4);
    rst_n = 1'b1;
    idle_cycles(2);
    t_reset();
    t_basic();
    t_wrap();
    t_small_ring();
    t_wb_off();
    t_soft_reset();
    idle_cycles(4);
    summary();
  end
endmodule